// File: doc/BRIEF.md
# Alarm Annunciation Arbiter and Horn Sequencer

This block turns a set of detector condition flags into the indications a smoke alarm presents. The flags are local alarm, remote alarm, push-test pass, push-test fail, low battery and degraded chamber. A fixed priority picks one winning condition on every clock. The winner drives a 3-bit code for an external sound controller, an enable for the horn boost stage and a visible LED.

All timing is counted in system ticks, nominally 10.5 ms each, supplied as a one-clock `tick` strobe.

- **Alarm conditions** produce the three-burst temporal horn cadence.
- **Warning conditions** produce short chirps, LED pulses and a code pulse once per long warning period. A low battery gives a single chirp; a degraded chamber gives a burst of three.
- **Standby** may blink the LED once per period, depending on a blink-enable input.

Whenever the winning condition changes, every timing counter restarts. The new indication therefore always begins at its first phase.

Top module: `alarm_annunciator`

## Requirements
- R1: `soundCode` takes these values, with bit 2 as the most significant bit. Standby 000, local 001, remote 010, test pass 011, test fail 100, low battery 101, degraded chamber 110. The alarm and test codes are held continuously while their condition wins.
- R2: Priority from highest to lowest is local, remote, test pass, test fail, degraded chamber, low battery.
- R3: While a local, remote, pass or fail condition is present, no warning code, chirp or warning LED pulse appears.
- R4: In local, remote and pass modes the horn repeats a 384-tick cadence: on 48, off 48, on 48, off 48, on 48, off 144.
- R5: In local, pass and fail modes the LED is lit for the first tick of every 48-tick slot, whatever the blink input. In remote mode the LED stays dark.
- R6: In low-battery mode, horn, LED and code 101 are all active during tick 0 of every 4096-tick period and inactive otherwise.
- R7: In degraded-chamber mode, horn and LED are active at period ticks 0, 64 and 128. Code 110 appears only at tick 0. The period is 4096 ticks.
- R8: In fail mode the horn is never enabled.
- R9: In standby the LED is lit during tick 0 of each 4096-tick period when `blinkEn` is 1, and never when it is 0. The horn stays off and the code is 000.
- R10: When the winning condition changes, all counters restart. On the clock after the flags are sampled, the outputs show phase 0 of the new condition.
- R11: Flags are sampled on every clock. Counters advance only on clocks where `tick` is 1.
- R12: While `rstN` is low, the block is in standby with its counters at zero, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock timing strobe, one per system tick |
| localAlarm | input | 1 | Smoke sensed by this unit |
| remoteAlarm | input | 1 | Alarm received from an interconnected unit |
| testPass | input | 1 | Push-test succeeded |
| testFail | input | 1 | Push-test failed |
| lowBattery | input | 1 | Supply below threshold |
| degradedChamber | input | 1 | Chamber sensitivity degraded |
| blinkEn | input | 1 | Enables the standby LED blink |
| soundCode | output | 3 | Code for the external sound controller |
| horn | output | 1 | Horn boost enable |
| led | output | 1 | Visible LED drive |

## Verification
Several properties are checked on every cycle:
- a local flag always yields code 001 on the next clock;
- any alarm or test flag blocks both warning codes;
- remote mode keeps the LED dark;
- fail mode keeps the horn silent;
- a restart zeroes the counters;
- the counters hold still between ticks.

The exact cadence phase boundaries, the chirp offsets and the wrap at the end of each period can only be shown by the bench's scenarios. The same holds for the ordering among the lower-priority conditions and the first-phase behaviour after a condition change. The bench runs a specific number of ticks and compares all three outputs.

// File: rtl/annun_pkg.sv
`timescale 1ns/1ps
package annun_pkg;

  // Mode encoding equals the sound-controller code of that mode.
  typedef enum logic [2:0] {
    M_STANDBY  = 3'b000,
    M_LOCAL    = 3'b001,
    M_REMOTE   = 3'b010,
    M_PASS     = 3'b011,
    M_FAIL     = 3'b100,
    M_LOWBAT   = 3'b101,
    M_DEGRADED = 3'b110
  } mode_e;

  // Control -> datapath strobes.
  typedef struct packed {
    logic restart;
    logic advance;
  } ctrlStrobe_t;

  // Datapath -> control phase flags.
  typedef struct packed {
    logic slotStart;    // first tick of a cadence slot
    logic hornSlot;     // cadence slot with horn on
    logic periodStart;  // first tick of the warning period
    logic chirpHit;     // one of the chirp ticks of the warning period
  } phase_t;

  // Fixed priority (R2): local > remote > pass > fail > degraded > low battery.
  function automatic mode_e pickMode(
    input logic localAlarm,
    input logic remoteAlarm,
    input logic testPass,
    input logic testFail,
    input logic degradedChamber,
    input logic lowBattery
  );
    if (localAlarm)           return M_LOCAL;
    else if (remoteAlarm)     return M_REMOTE;
    else if (testPass)        return M_PASS;
    else if (testFail)        return M_FAIL;
    else if (degradedChamber) return M_DEGRADED;
    else if (lowBattery)      return M_LOWBAT;
    else                      return M_STANDBY;
  endfunction

endpackage

// File: rtl/annun_timebase.sv
`timescale 1ns/1ps
module annun_timebase
  import annun_pkg::*;
#(
  parameter int SLOT_TICKS  = 48,
  parameter int BURSTS      = 3,
  parameter int WARN_PERIOD = 4096,
  parameter int CHIRP_GAP   = 64,
  parameter int CHIRP_COUNT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output phase_t      phase
);

  // Cadence: BURSTS on/off pairs, with the last off phase stretched by two
  // extra slots.
  localparam int SLOTS  = 2 * BURSTS + 2;
  localparam int SUB_W  = (SLOT_TICKS  > 1) ? $clog2(SLOT_TICKS)  : 1;
  localparam int SLOT_W = (SLOTS       > 1) ? $clog2(SLOTS)       : 1;
  localparam int PER_W  = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;

  logic [SUB_W-1:0]  subQ;
  logic [SLOT_W-1:0] slotQ;
  logic [PER_W-1:0]  perQ;

  logic subLast, slotLast, perLast;
  assign subLast  = (subQ  == SUB_W'(SLOT_TICKS - 1));
  assign slotLast = (slotQ == SLOT_W'(SLOTS - 1));
  assign perLast  = (perQ  == PER_W'(WARN_PERIOD - 1));

  // Cadence counters.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      subQ  <= '0;
      slotQ <= '0;
    end else if (strobe.advance) begin
      if (subLast) begin
        subQ  <= '0;
        slotQ <= slotLast ? '0 : slotQ + SLOT_W'(1);
      end else begin
        subQ  <= subQ + SUB_W'(1);
      end
    end
  end

  // Warning period counter.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      perQ <= '0;
    end else if (strobe.advance) begin
      perQ <= perLast ? '0 : perQ + PER_W'(1);
    end
  end

  // Chirp tick decoders, one per chirp.
  logic [CHIRP_COUNT-1:0] hitVec;
  for (genvar k = 0; k < CHIRP_COUNT; k++) begin : g_chirp
    localparam int OFFSET = k * CHIRP_GAP;
    assign hitVec[k] = (perQ == PER_W'(OFFSET));
  end

  assign phase.slotStart   = (subQ == '0);
  assign phase.hornSlot    = (slotQ < SLOT_W'(2 * BURSTS)) && !slotQ[0];
  assign phase.periodStart = (perQ == '0);
  assign phase.chirpHit    = |hitVec;

  // R10: a restart leaves every counter at zero.
  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (subQ == '0 && slotQ == '0 && perQ == '0));

  // R11: without a tick or a restart, the counters hold.
  p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.restart) |=> $stable({subQ, slotQ, perQ}));

endmodule

// File: rtl/annun_ctrl.sv
`timescale 1ns/1ps
module annun_ctrl
  import annun_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        localAlarm,
  input  logic        remoteAlarm,
  input  logic        testPass,
  input  logic        testFail,
  input  logic        lowBattery,
  input  logic        degradedChamber,
  input  logic        blinkEn,
  input  phase_t      phase,
  output ctrlStrobe_t strobe,
  output logic [2:0]  soundCode,
  output logic        horn,
  output logic        led
);

  mode_e modeQ, modeD;

  assign modeD = pickMode(localAlarm, remoteAlarm, testPass, testFail,
                          degradedChamber, lowBattery);

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= M_STANDBY;
    else       modeQ <= modeD;
  end

  assign strobe.restart = (modeD != modeQ);
  assign strobe.advance = tick;

  // Output decode per mode.
  always_comb begin
    soundCode = 3'b000;
    horn      = 1'b0;
    led       = 1'b0;
    unique case (modeQ)
      M_LOCAL, M_PASS: begin
        soundCode = modeQ;
        horn      = phase.hornSlot;
        led       = phase.slotStart;
      end
      M_REMOTE: begin
        soundCode = modeQ;
        horn      = phase.hornSlot;
      end
      M_FAIL: begin
        soundCode = modeQ;
        led       = phase.slotStart;
      end
      M_LOWBAT: begin
        soundCode = phase.periodStart ? modeQ : 3'b000;
        horn      = phase.periodStart;
        led       = phase.periodStart;
      end
      M_DEGRADED: begin
        soundCode = phase.periodStart ? modeQ : 3'b000;
        horn      = phase.chirpHit;
        led       = phase.chirpHit;
      end
      default: begin
        led = blinkEn && phase.periodStart;
      end
    endcase
  end

  // R2: a sampled local flag always wins on the next clock.
  p_local_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(localAlarm)) |-> soundCode == 3'b001);

  // R3: alarm or test flags block both warning codes.
  p_warn_inhibit_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(localAlarm || remoteAlarm || testPass || testFail))
      |-> !(soundCode == 3'b101 || soundCode == 3'b110));

  // R5: remote mode never lights the LED.
  p_remote_dark_r5: assert property (@(posedge clk) disable iff (!rstN)
    soundCode == 3'b010 |-> !led);

  // R8: fail mode keeps the horn silent.
  p_fail_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    soundCode == 3'b100 |-> !horn);

endmodule

// File: rtl/alarm_annunciator.sv
`timescale 1ns/1ps
module alarm_annunciator
  import annun_pkg::*;
#(
  parameter int SLOT_TICKS  = 48,
  parameter int BURSTS      = 3,
  parameter int WARN_PERIOD = 4096,
  parameter int CHIRP_GAP   = 64,
  parameter int CHIRP_COUNT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       localAlarm,
  input  logic       remoteAlarm,
  input  logic       testPass,
  input  logic       testFail,
  input  logic       lowBattery,
  input  logic       degradedChamber,
  input  logic       blinkEn,
  output logic [2:0] soundCode,
  output logic       horn,
  output logic       led
);

  ctrlStrobe_t strobe;
  phase_t      phase;

  annun_ctrl ctrl_i (
    .clk             (clk),
    .rstN            (rstN),
    .tick            (tick),
    .localAlarm      (localAlarm),
    .remoteAlarm     (remoteAlarm),
    .testPass        (testPass),
    .testFail        (testFail),
    .lowBattery      (lowBattery),
    .degradedChamber (degradedChamber),
    .blinkEn         (blinkEn),
    .phase           (phase),
    .strobe          (strobe),
    .soundCode       (soundCode),
    .horn            (horn),
    .led             (led)
  );

  annun_timebase #(
    .SLOT_TICKS  (SLOT_TICKS),
    .BURSTS      (BURSTS),
    .WARN_PERIOD (WARN_PERIOD),
    .CHIRP_GAP   (CHIRP_GAP),
    .CHIRP_COUNT (CHIRP_COUNT)
  ) timebase_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .phase  (phase)
  );

endmodule

// File: tb/alarm_annunciator_tb.sv
`timescale 1ns/1ps
module alarm_annunciator_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic localAlarm = 1'b0, remoteAlarm = 1'b0, testPass = 1'b0, testFail = 1'b0;
  logic lowBattery = 1'b0, degradedChamber = 1'b0, blinkEn = 1'b0;
  logic [2:0] soundCode;
  logic horn, led;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  alarm_annunciator dut_i (
    .clk(clk), .rstN(rstN), .tick(tick),
    .localAlarm(localAlarm), .remoteAlarm(remoteAlarm),
    .testPass(testPass), .testFail(testFail),
    .lowBattery(lowBattery), .degradedChamber(degradedChamber),
    .blinkEn(blinkEn), .soundCode(soundCode), .horn(horn), .led(led)
  );

  // Vector layout: [24:19] flags {local,remote,pass,fail,lowbat,degraded},
  // [18] blink, [17:5] ticks after entry, [4:2] code, [1] horn, [0] led.
  localparam int NV = 32;
  localparam logic [24:0] VEC [NV] = '{
    {6'b000000, 1'b1, 13'd0,    3'b000, 1'b0, 1'b1},
    {6'b000000, 1'b1, 13'd1,    3'b000, 1'b0, 1'b0},
    {6'b000000, 1'b0, 13'd0,    3'b000, 1'b0, 1'b0},
    {6'b100000, 1'b0, 13'd0,    3'b001, 1'b1, 1'b1},
    {6'b100000, 1'b0, 13'd47,   3'b001, 1'b1, 1'b0},
    {6'b100000, 1'b0, 13'd48,   3'b001, 1'b0, 1'b1},
    {6'b100000, 1'b0, 13'd96,   3'b001, 1'b1, 1'b1},
    {6'b100000, 1'b0, 13'd240,  3'b001, 1'b0, 1'b1},
    {6'b100000, 1'b0, 13'd383,  3'b001, 1'b0, 1'b0},
    {6'b100000, 1'b0, 13'd384,  3'b001, 1'b1, 1'b1},
    {6'b010000, 1'b0, 13'd0,    3'b010, 1'b1, 1'b0},
    {6'b010000, 1'b0, 13'd200,  3'b010, 1'b1, 1'b0},
    {6'b001000, 1'b0, 13'd0,    3'b011, 1'b1, 1'b1},
    {6'b001000, 1'b0, 13'd150,  3'b011, 1'b0, 1'b0},
    {6'b000100, 1'b0, 13'd0,    3'b100, 1'b0, 1'b1},
    {6'b000100, 1'b0, 13'd96,   3'b100, 1'b0, 1'b1},
    {6'b000010, 1'b0, 13'd0,    3'b101, 1'b1, 1'b1},
    {6'b000010, 1'b0, 13'd1,    3'b000, 1'b0, 1'b0},
    {6'b000010, 1'b0, 13'd4096, 3'b101, 1'b1, 1'b1},
    {6'b000001, 1'b0, 13'd0,    3'b110, 1'b1, 1'b1},
    {6'b000001, 1'b0, 13'd64,   3'b000, 1'b1, 1'b1},
    {6'b000001, 1'b0, 13'd128,  3'b000, 1'b1, 1'b1},
    {6'b000001, 1'b0, 13'd65,   3'b000, 1'b0, 1'b0},
    {6'b000001, 1'b0, 13'd192,  3'b000, 1'b0, 1'b0},
    {6'b111000, 1'b0, 13'd0,    3'b001, 1'b1, 1'b1},
    {6'b011100, 1'b0, 13'd0,    3'b010, 1'b1, 1'b0},
    {6'b001100, 1'b0, 13'd0,    3'b011, 1'b1, 1'b1},
    {6'b100010, 1'b0, 13'd1,    3'b001, 1'b1, 1'b0},
    {6'b000101, 1'b0, 13'd0,    3'b100, 1'b0, 1'b1},
    {6'b000011, 1'b0, 13'd0,    3'b110, 1'b1, 1'b1},
    {6'b000010, 1'b1, 13'd0,    3'b101, 1'b1, 1'b1},
    {6'b100000, 1'b1, 13'd0,    3'b001, 1'b1, 1'b1}
  };
  localparam string VREQ [NV] = '{
    "R9", "R9", "R9", "R4", "R5", "R4", "R4", "R4", "R4", "R4",
    "R5", "R1", "R1", "R4", "R8", "R8", "R6", "R6", "R6", "R7",
    "R7", "R7", "R7", "R7", "R2", "R2", "R2", "R3", "R3", "R2",
    "R6", "R5"
  };

  task automatic check(input string req, input logic [2:0] eCode,
                       input logic eHorn, input logic eLed);
    nChecks++;
    if (soundCode !== eCode || horn !== eHorn || led !== eLed) begin
      nFails++;
      $display("FAIL %s: code/horn/led actual %b/%b/%b expected %b/%b/%b",
               req, soundCode, horn, led, eCode, eHorn, eLed);
    end
  endtask

  task automatic setFlags(input logic [5:0] f);
    {localAlarm, remoteAlarm, testPass, testFail, lowBattery, degradedChamber} = f;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    tick = 1'b0;
    setFlags(6'b000000);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doTicks(input int n);
    for (int t = 0; t < n; t++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    // R12: reset holds standby with flags asserted.
    blinkEn = 1'b0;
    rstN = 1'b0;
    localAlarm = 1'b1;
    lowBattery = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", 3'b000, 1'b0, 1'b0);

    // Table walk: each vector starts from reset.
    for (int i = 0; i < NV; i++) begin
      blinkEn = VEC[i][18];
      applyReset();
      setFlags(VEC[i][24:19]);
      @(negedge clk);
      doTicks(int'(VEC[i][17:5]));
      check(VREQ[i], VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // R12: standby right after reset, blink on, counters at zero.
    blinkEn = 1'b1;
    applyReset();
    @(negedge clk);
    check("R12", 3'b000, 1'b0, 1'b1);

    // R10: switching condition mid-cadence restarts at phase 0.
    blinkEn = 1'b0;
    applyReset();
    setFlags(6'b100000);
    @(negedge clk);
    doTicks(50);
    check("R4", 3'b001, 1'b0, 1'b0);
    setFlags(6'b010000);
    @(negedge clk);
    check("R10", 3'b010, 1'b1, 1'b0);

    // R10: warning to standby restarts the blink period.
    blinkEn = 1'b1;
    applyReset();
    setFlags(6'b000010);
    @(negedge clk);
    doTicks(5);
    setFlags(6'b000000);
    @(negedge clk);
    check("R10", 3'b000, 1'b0, 1'b1);

    // R11: no progress without tick, one tick advances.
    blinkEn = 1'b0;
    applyReset();
    setFlags(6'b100000);
    repeat (21) @(negedge clk);
    check("R11", 3'b001, 1'b1, 1'b1);
    doTicks(1);
    check("R11", 3'b001, 1'b1, 1'b0);

    finishRun();
  end

endmodule